// File: doc/BRIEF.md
# SMBus-aware I2C Slave Address Recognizer

This block sits behind the bit sampler of an I2C slave and judges the address byte that follows every START or repeated START. It collects eight address bits, one per bit-valid strobe and most significant bit first. It then decides whether the slave acknowledges the byte, and holds that decision for the ninth (acknowledge) bit period. Besides the programmed 7-bit own address, it can accept four reserved addresses, each under its own enable: general call, SMBus host, SMBus device default and the SMBus alert response address.

The alert response address is honoured only in device mode (host recognition off) while the alert enable is set. In that same mode and state, the block pulls the open-drain alert output low. A recognized address raises a one-cycle match event, which is forwarded as an interrupt pulse only when the match interrupt enable is set. After a rejected address, the rest of the transfer is ignored until the next START or STOP. Nothing is recognized while the block enable is low.

Top module: `smb_addr_filter`

## Requirements
- R1: With the block enabled, an address byte whose upper seven bits equal `own_addr` is acknowledged (`ack_drive`=1) with `match_code`=1, for either R/W bit value.
- R2: Byte 0x00 is acknowledged with `match_code`=2 when `gcall_en`=1 and rejected when it is 0. Byte 0x01 (read) is never treated as a general call.
- R3: Bytes 0x10/0x11 (address 0001000, either R/W bit) are acknowledged with `match_code`=3 only when `host_en`=1.
- R4: Bytes 0xC2/0xC3 (address 1100001, either R/W bit) are acknowledged with `match_code`=4 only when `devdef_en`=1.
- R5: Bytes 0x18/0x19 (address 0001100, either R/W bit) are acknowledged with `match_code`=5 only when `alert_en`=1 and `host_en`=0. With `host_en`=1 they are rejected whatever `alert_en` is.
- R6: `alert_n` is 0 exactly when, one cycle earlier, `enable`=1, `alert_en`=1 and `host_en`=0. Otherwise it is 1. It is 1 during reset.
- R7: While `enable`=0, no address is acknowledged, no match event is raised and `alert_n` stays 1.
- R8: A recognized address raises `match_evt` for exactly one cycle. `match_irq` pulses in that same cycle only if `match_ie` was 1.
- R9: `ack_drive`, `match_code` and `match_evt` take their new values in the cycle after the eighth bit strobe. `ack_drive` returns to 0 in the cycle after the ninth strobe.
- R10: When the own address also equals a reserved address that is enabled, `match_code` reports 1 (own address has priority).
- R11: A START restarts the bit count. A START in the same cycle as the eighth bit strobe cancels that byte: no acknowledge and no event.
- R12: After a STOP, bit strobes are ignored until the next START.
- R13: After a rejected address byte, later bytes of the same transfer are neither acknowledged nor reported, even if they match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable; 0 disables all recognition |
| own_addr | input | 7 | Programmed 7-bit slave address |
| gcall_en | input | 1 | Accept general call byte 0x00 |
| host_en | input | 1 | Accept SMBus host address; also selects host mode |
| devdef_en | input | 1 | Accept SMBus device default address |
| alert_en | input | 1 | Device mode: raise alert and accept alert response address |
| match_ie | input | 1 | Forward match events to `match_irq` |
| sda_bit | input | 1 | Sampled data line value, valid with `bit_strobe` |
| bit_strobe | input | 1 | One-cycle pulse per sampled bit (clock rising edge) |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on STOP |
| ack_drive | output | 1 | 1 = pull data line low in the acknowledge bit |
| match_code | output | 3 | 0 none, 1 own, 2 general call, 3 host, 4 device default, 5 alert response |
| match_evt | output | 1 | One-cycle pulse on a recognized address |
| match_irq | output | 1 | Match event gated by `match_ie` |
| alert_n | output | 1 | Alert output; 0 = drive low, 1 = released |

## Verification
A START pulse can land in the same cycle as the strobe of the eighth address bit. In that case the restart has to win over the byte decision. The bench drives seven bits, then raises `start_seen` together with the eighth strobe. It expects no acknowledge and no event. It then sends a complete own-address byte and expects a normal acknowledge, which shows that the count really restarted at zero. The bench also changes `host_en` between table entries that use the alert response address. This checks that a mode change alters both the acknowledge decision and the alert output.

// File: rtl/smbaf_pkg.sv
package smbaf_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int N_KIND = 5;

    localparam logic [ADDR_W-1:0] HOST_ADDR   = 7'h08;
    localparam logic [ADDR_W-1:0] DEVDEF_ADDR = 7'h61;
    localparam logic [ADDR_W-1:0] ARA_ADDR    = 7'h0C;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_OWN    = 3'd1,
        KIND_GCALL  = 3'd2,
        KIND_HOST   = 3'd3,
        KIND_DEVDEF = 3'd4,
        KIND_ARA    = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] own_addr;
        logic              gcall_en;
        logic              host_en;
        logic              devdef_en;
        logic              alert_en;
    } cfg_t;

    // Alert response is live only in device mode with the alert raised
    function automatic logic ara_live(cfg_t c);
        return c.alert_en && !c.host_en;
    endfunction

endpackage

// File: rtl/smbaf_shifter.sv
module smbaf_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-2:0]  sh;
    logic          last;

    assign last = (cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (shift_en) begin
            sh  <= {sh[W-3:0], bit_in};
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    assign byte_done = shift_en && last && !clr;
    assign byte_val  = {sh, bit_in};
endmodule

// File: rtl/smbaf_classify.sv
module smbaf_classify
    import smbaf_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_val,
    input  cfg_t              cfg,
    output kind_e             kind
);
    logic [ADDR_W-1:0] addr;
    logic [N_KIND-1:0] hit;

    assign addr = byte_val[BYTE_W-1:1];

    always_comb begin
        hit[0] = (addr == cfg.own_addr);
        hit[1] = (byte_val == '0) && cfg.gcall_en;
        hit[2] = (addr == HOST_ADDR) && cfg.host_en;
        hit[3] = (addr == DEVDEF_ADDR) && cfg.devdef_en;
        hit[4] = (addr == ARA_ADDR) && ara_live(cfg);
    end

    // lowest index wins: walk from lowest priority upward
    always_comb begin
        kind = KIND_NONE;
        for (int i = N_KIND - 1; i >= 0; i--) begin
            if (hit[i]) kind = kind_e'(3'(i + 1));
        end
    end
endmodule

// File: rtl/smbaf_ctrl.sv
module smbaf_ctrl
    import smbaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       start_seen,
    input  logic       stop_seen,
    input  logic       bit_strobe,
    input  logic       byte_done,
    input  kind_e      kind,
    input  logic       alert_req,
    input  logic       match_ie,
    output logic       clr,
    output logic       shift_en,
    output logic       ack_drive,
    output logic [2:0] match_code,
    output logic       match_evt,
    output logic       match_irq,
    output logic       alert_n
);
    state_e state;
    logic   ack_q, evt_q, irq_q, alert_q;
    kind_e  code_q;
    logic   hit;

    assign clr      = !enable || start_seen || stop_seen;
    assign shift_en = bit_strobe && (state == ST_ADDR);
    assign hit      = byte_done && (kind != KIND_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ack_q  <= 1'b0;
            code_q <= KIND_NONE;
        end else if (clr) begin
            state  <= (enable && start_seen && !stop_seen) ? ST_ADDR : ST_IDLE;
            ack_q  <= 1'b0;
            code_q <= KIND_NONE;
        end else begin
            case (state)
                ST_ADDR: if (byte_done) begin
                    state  <= ST_ACK;
                    ack_q  <= (kind != KIND_NONE);
                    code_q <= kind;
                end
                ST_ACK: if (bit_strobe) begin
                    state <= ST_WAIT;
                    ack_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q   <= 1'b0;
            irq_q   <= 1'b0;
            alert_q <= 1'b1;
        end else begin
            evt_q   <= hit;
            irq_q   <= hit && match_ie;
            alert_q <= !(enable && alert_req);
        end
    end

    assign ack_drive  = ack_q;
    assign match_code = code_q;
    assign match_evt  = evt_q;
    assign match_irq  = irq_q;
    assign alert_n    = alert_q;
endmodule

// File: rtl/smb_addr_filter.sv
module smb_addr_filter
    import smbaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [6:0] own_addr,
    input  logic       gcall_en,
    input  logic       host_en,
    input  logic       devdef_en,
    input  logic       alert_en,
    input  logic       match_ie,
    input  logic       sda_bit,
    input  logic       bit_strobe,
    input  logic       start_seen,
    input  logic       stop_seen,
    output logic       ack_drive,
    output logic [2:0] match_code,
    output logic       match_evt,
    output logic       match_irq,
    output logic       alert_n
);
    cfg_t              cfg;
    logic              clr, shift_en, byte_done;
    logic [BYTE_W-1:0] byte_val;
    kind_e             kind;

    assign cfg = '{own_addr: own_addr, gcall_en: gcall_en, host_en: host_en,
                   devdef_en: devdef_en, alert_en: alert_en};

    smbaf_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .clr(clr), .shift_en(shift_en),
        .bit_in(sda_bit), .byte_done(byte_done), .byte_val(byte_val)
    );

    smbaf_classify u_cls (
        .byte_val(byte_val), .cfg(cfg), .kind(kind)
    );

    smbaf_ctrl u_ctrl (
        .clk(clk), .rst(rst), .enable(enable), .start_seen(start_seen),
        .stop_seen(stop_seen), .bit_strobe(bit_strobe), .byte_done(byte_done),
        .kind(kind), .alert_req(ara_live(cfg)), .match_ie(match_ie),
        .clr(clr), .shift_en(shift_en), .ack_drive(ack_drive),
        .match_code(match_code), .match_evt(match_evt), .match_irq(match_irq),
        .alert_n(alert_n)
    );
endmodule

// File: rtl/smbaf_checker.sv
module smbaf_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       host_en,
    input logic       alert_en,
    input logic       match_ie,
    input logic       bit_strobe,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       ack_drive,
    input logic [2:0] match_code,
    input logic       match_evt,
    input logic       match_irq
);
    // R7: disabled block acknowledges nothing
    p_no_ack_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!ack_drive && !match_evt));

    // R8: interrupt only with an event and the enable set
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
        match_irq |-> (match_evt && $past(match_ie)));

    // R8: event is a single-cycle pulse
    p_evt_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> !match_evt);

    // R5: alert response accepted only in device mode with alert raised
    p_ara_device_only_r5: assert property (@(posedge clk) disable iff (rst)
        (match_evt && match_code == 3'd5) |-> $past(alert_en && !host_en));

    // R1: an acknowledge always carries a match class
    p_ack_has_code_r1: assert property (@(posedge clk) disable iff (rst)
        ack_drive |-> (match_code != 3'd0));

    // R9: ninth strobe ends the acknowledge
    p_ack_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_drive && bit_strobe && !start_seen && !stop_seen && enable) |=> !ack_drive);
endmodule

bind smb_addr_filter smbaf_checker u_chk (.*);

// File: tb/smb_addr_filter_bench.sv
`timescale 1ns/1ps
module smb_addr_filter_bench;

    typedef struct packed {
        logic [7:0] byte_v;
        logic       gc;
        logic       host;
        logic       dev;
        logic       alert;
        logic       exp_ack;
        logic [2:0] exp_code;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TABLE [NV] = '{
        '{8'h54, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1},
        '{8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1},
        '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2},
        '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3},
        '{8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{8'hC2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4},
        '{8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{8'h18, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5},
        '{8'h19, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{8'h18, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
        '{8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [6:0] own_addr = 7'h2A;
    logic       gcall_en = 1'b0, host_en = 1'b0, devdef_en = 1'b0, alert_en = 1'b0;
    logic       match_ie = 1'b1;
    logic       sda_bit = 1'b0, bit_strobe = 1'b0, start_seen = 1'b0, stop_seen = 1'b0;
    logic       ack_drive, match_evt, match_irq, alert_n;
    logic [2:0] match_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    smb_addr_filter u_smb_addr_filter (
        .clk(clk), .rst(rst), .enable(enable), .own_addr(own_addr),
        .gcall_en(gcall_en), .host_en(host_en), .devdef_en(devdef_en),
        .alert_en(alert_en), .match_ie(match_ie), .sda_bit(sda_bit),
        .bit_strobe(bit_strobe), .start_seen(start_seen), .stop_seen(stop_seen),
        .ack_drive(ack_drive), .match_code(match_code), .match_evt(match_evt),
        .match_irq(match_irq), .alert_n(alert_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic with_start = 1'b0);
        @(negedge clk);
        sda_bit    = b;
        bit_strobe = 1'b1;
        start_seen = with_start;
        @(negedge clk);
        bit_strobe = 1'b0;
        start_seen = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int b = 7; b >= 0; b--) send_bit(v[b]);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_seen = 1'b1;
        @(negedge clk);
        start_seen = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
    endtask

    function automatic string tag_of(input int idx);
        case (idx)
            0, 1:    return "R1 own address";
            2, 3, 11: return "R2 general call";
            4, 5:    return "R3 host address";
            6, 7:    return "R4 device default";
            default: return "R5 alert response";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R6 released alert, R9 no acknowledge)
        check("R9 reset ack_drive", ack_drive, 0);
        check("R9 reset match_code", match_code, 0);
        check("R8 reset match_evt", match_evt, 0);
        check("R8 reset match_irq", match_irq, 0);
        check("R6 reset alert_n", alert_n, 1);
        rst = 1'b0;
        enable = 1'b1;

        // table walk: classes and enables
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            gcall_en = TABLE[i].gc;
            host_en  = TABLE[i].host;
            devdef_en = TABLE[i].dev;
            alert_en = TABLE[i].alert;
            @(negedge clk);
            check("R6 alert_n per mode", alert_n, (TABLE[i].alert && !TABLE[i].host) ? 0 : 1);
            pulse_start();
            send_byte(TABLE[i].byte_v);
            check(tag_of(i), ack_drive, TABLE[i].exp_ack);
            check(tag_of(i), match_code, TABLE[i].exp_code);
            check("R8 event on match", match_evt, TABLE[i].exp_ack);
            check("R8 irq with enable", match_irq, TABLE[i].exp_ack);
            send_bit(1'b0);
            check("R9 ack released after ninth bit", ack_drive, 0);
            pulse_stop();
        end
        gcall_en = 0; host_en = 0; devdef_en = 0; alert_en = 0;

        // R8: interrupt masked
        match_ie = 1'b0;
        pulse_start();
        send_byte(8'h54);
        check("R8 event with irq masked", match_evt, 1);
        check("R8 irq masked", match_irq, 0);
        @(negedge clk);
        check("R8 event lasts one cycle", match_evt, 0);
        match_ie = 1'b1;
        pulse_stop();

        // R9: decision timing
        pulse_start();
        send_byte(8'h54);
        check("R9 ack after eighth bit", ack_drive, 1);
        @(negedge clk);
        check("R9 ack held until ninth strobe", ack_drive, 1);
        send_bit(1'b0);
        check("R9 ack dropped after ninth strobe", ack_drive, 0);
        pulse_stop();

        // R10: own address equal to enabled host address
        own_addr = 7'h08;
        host_en  = 1'b1;
        pulse_start();
        send_byte(8'h10);
        check("R10 own has priority", match_code, 1);
        pulse_stop();
        own_addr = 7'h2A;
        host_en  = 1'b0;

        // R7: disabled
        enable   = 1'b0;
        alert_en = 1'b1;
        pulse_start();
        send_byte(8'h54);
        check("R7 no ack when disabled", ack_drive, 0);
        check("R7 no event when disabled", match_evt, 0);
        check("R7 alert released when disabled", alert_n, 1);
        alert_en = 1'b0;
        enable   = 1'b1;
        pulse_stop();

        // R11: restart mid-byte
        pulse_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        pulse_start();
        send_byte(8'h54);
        check("R11 restart mid-byte then own", ack_drive, 1);
        pulse_stop();

        // R11: START together with eighth strobe cancels the byte
        pulse_start();
        for (int b = 7; b >= 1; b--) send_bit(8'h54 >> b);
        send_bit(1'b0, 1'b1);
        check("R11 start on eighth bit no ack", ack_drive, 0);
        check("R11 start on eighth bit no event", match_evt, 0);
        send_byte(8'h54);
        check("R11 full byte after collision", ack_drive, 1);
        check("R11 code after collision", match_code, 1);
        send_bit(1'b0);

        // R12: strobes ignored after STOP
        pulse_stop();
        send_byte(8'h54);
        check("R12 no ack after stop", ack_drive, 0);
        check("R12 no event after stop", match_evt, 0);

        // R13: mismatch ignores rest of transfer
        pulse_start();
        send_byte(8'h40);
        check("R13 mismatch rejected", ack_drive, 0);
        send_bit(1'b1);
        send_byte(8'h54);
        check("R13 later byte ignored ack", ack_drive, 0);
        check("R13 later byte ignored event", match_evt, 0);
        check("R13 later byte code", match_code, 0);
        pulse_stop();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule